// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block moves a chosen group of CPU registers to or from a byte-wide stack in memory, one byte per clock. An 8-bit selection mask picks the registers. The command can use either the system stack pointer S or the user stack pointer U. The mask slot that names "the other stack pointer" then refers to whichever of the two is not in use. Words are split into two bytes in big-endian order. A push walks the slots from the highest bit down and decrements the pointer before each byte. A pull walks from the lowest bit up, reads at the pointer and then increments it.

Two fixed sequences are built on the same engine:
- **Software interrupt entry** saves the whole register file on S. It then raises three control bits in the condition-code register and fetches the new program counter from a fixed vector.
- **Interrupt return** first restores the condition codes. Their top bit then decides whether the rest of the register file comes back, or only the program counter.

The CPU presents its current register values on read buses and receives restored values on a single write bus. The working stack pointer is returned only once, together with a one-cycle done pulse.

Top module: `stack_xfer_seq`

## Requirements
- R1: A push command (cmd_op = 0) walks the set mask bits from 7 down to 0. Before each byte it lowers the stack pointer by one, wrapping modulo 2^16, and writes at the new value. A word register writes its low byte first, so its high byte lands at the lower address.
- R2: A pull command (cmd_op = 1) walks the set mask bits from 0 up to 7. It reads at the stack pointer and then raises it by one. A word register reads its high byte first, and its write-bus transfer occurs on its second byte. Byte registers are written zero-extended in the cycle they are read.
- R3: Mask bit n names slot n, and wr_slot carries n. The slots are: 0 condition codes, 1 accumulator A, 2 accumulator B, 3 direct page, 4 X, 5 Y, 6 the stack pointer not in use, 7 program counter. Slots 4 to 7 are 16-bit words.
- R4: With cmd_use_u = 1 the sequence starts from rd_u and slot 6 carries S. With cmd_use_u = 0 it starts from rd_s and slot 6 carries U.
- R5: Exactly one memory byte is transferred in every cycle after the accepting edge until the last byte, and done follows in the next cycle.
- R6: A software-interrupt command (cmd_op = 2) always uses S and ignores cmd_mask and cmd_use_u. It pushes all eight slots as in R1. Next it reads address FFFA and writes slot 0 with rd_cc OR D0 (hex). Then it reads FFFB and writes slot 7 with {byte at FFFA, byte at FFFB}.
- R7: A return command (cmd_op = 3) always uses S and ignores cmd_mask and cmd_use_u. It pulls slot 0 first. If bit 7 of that byte is set, it then pulls slots 1 to 7 in order; otherwise it pulls only slot 7.
- R8: A push or pull with an all-zero mask raises done in the cycle after acceptance, makes no memory access, and returns the starting stack pointer unchanged.
- R9: done is a single-cycle pulse. With it come done_sp (the final stack pointer) and done_use_u (which pointer it belongs to: 1 for U). The pointer in use never appears on the register write bus.
- R10: cmd_valid is ignored while busy is high. After done, no further activity starts unless cmd_valid is high during an idle cycle.
- R11: During and after reset the block is idle: busy, mem_en, wr_en and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken in an idle cycle |
| cmd_op | input | 2 | 0 push, 1 pull, 2 interrupt entry, 3 interrupt return |
| cmd_mask | input | 8 | Slot selection for push and pull |
| cmd_use_u | input | 1 | Use U instead of S for push and pull |
| busy | output | 1 | A command is in progress |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_addr |
| rd_pc | input | 16 | Program counter value |
| rd_s | input | 16 | System stack pointer value |
| rd_u | input | 16 | User stack pointer value |
| rd_y | input | 16 | Y index value |
| rd_x | input | 16 | X index value |
| rd_dp | input | 8 | Direct page value |
| rd_b | input | 8 | Accumulator B value |
| rd_a | input | 8 | Accumulator A value |
| rd_cc | input | 8 | Condition codes value |
| wr_en | output | 1 | Register write strobe |
| wr_slot | output | 3 | Slot being written (R3 numbering) |
| wr_data | output | 16 | Value to write; bytes zero-extended |
| done | output | 1 | Command complete (one cycle) |
| done_use_u | output | 1 | done_sp belongs to U when 1, S when 0 |
| done_sp | output | 16 | Final stack pointer value |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, 16-bit words, vector at FFFA, D0 as the set pattern and bit 7 as the restore-all flag. Because the pointer is a full 16 bits, a push from 0001 crosses 0000 to FFFF and exercises the wrap. The bench memory decodes only the low address byte, so the vector bytes and both stacks stay reachable in a small array. Its reference model predicts every cycle of memory, write-bus and done activity, covering full and partial masks on both stacks, the two interrupt sequences with both values of the restore flag, and a command held high while busy.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
    localparam int unsigned MASK_W = 8;
    localparam int unsigned IDX_W  = $clog2(MASK_W);

    localparam logic [IDX_W-1:0] SLOT_CC   = IDX_W'(0);
    localparam logic [IDX_W-1:0] SLOT_WORD = IDX_W'(4);
    localparam logic [IDX_W-1:0] SLOT_PC   = IDX_W'(7);

    typedef enum logic [1:0] {
        OP_PUSH = 2'd0,
        OP_PULL = 2'd1,
        OP_SWI  = 2'd2,
        OP_RTI  = 2'd3
    } sxs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_XFER   = 3'd1,
        ST_VEC_HI = 3'd2,
        ST_VEC_LO = 3'd3,
        ST_FIN    = 3'd4
    } sxs_state_e;
endpackage

// File: rtl/sxs_pick.sv
// Chooses the next slot from the remaining mask: highest set bit when
// descending (push), lowest set bit when ascending (pull).
module sxs_pick
    import sxs_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic              ascend,
    output logic [IDX_W-1:0]  idx,
    output logic              found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        if (ascend) begin
            for (int i = MASK_W - 1; i >= 0; i--) begin
                if (mask[i]) begin
                    idx   = IDX_W'(i);
                    found = 1'b1;
                end
            end
        end else begin
            for (int i = 0; i < MASK_W; i++) begin
                if (mask[i]) begin
                    idx   = IDX_W'(i);
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sxs_srcmux.sv
// Selects the register value for a slot; byte slots are zero-extended.
module sxs_srcmux
    import sxs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic [IDX_W-1:0]  slot,
    input  logic              use_u,
    input  logic [WORD_W-1:0] rd_pc,
    input  logic [WORD_W-1:0] rd_s,
    input  logic [WORD_W-1:0] rd_u,
    input  logic [WORD_W-1:0] rd_y,
    input  logic [WORD_W-1:0] rd_x,
    input  logic [BYTE_W-1:0] rd_dp,
    input  logic [BYTE_W-1:0] rd_b,
    input  logic [BYTE_W-1:0] rd_a,
    input  logic [BYTE_W-1:0] rd_cc,
    output logic [WORD_W-1:0] value
);
    localparam logic [BYTE_W-1:0] ZB = '0;

    always_comb begin
        unique case (slot)
            3'd7:    value = rd_pc;
            3'd6:    value = use_u ? rd_s : rd_u;
            3'd5:    value = rd_y;
            3'd4:    value = rd_x;
            3'd3:    value = {ZB, rd_dp};
            3'd2:    value = {ZB, rd_b};
            3'd1:    value = {ZB, rd_a};
            default: value = {ZB, rd_cc};
        endcase
    end
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
    import sxs_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter logic [2*BYTE_W-1:0] VEC_ADDR = 16'hFFFA,
    parameter logic [BYTE_W-1:0] SWI_CC_SET = 8'hD0,
    parameter int unsigned E_BIT = 7,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [7:0]        cmd_mask,
    input  logic              cmd_use_u,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] rd_pc,
    input  logic [WORD_W-1:0] rd_s,
    input  logic [WORD_W-1:0] rd_u,
    input  logic [WORD_W-1:0] rd_y,
    input  logic [WORD_W-1:0] rd_x,
    input  logic [BYTE_W-1:0] rd_dp,
    input  logic [BYTE_W-1:0] rd_b,
    input  logic [BYTE_W-1:0] rd_a,
    input  logic [BYTE_W-1:0] rd_cc,
    output logic              wr_en,
    output logic [2:0]        wr_slot,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              done_use_u,
    output logic [WORD_W-1:0] done_sp
);
    localparam logic [BYTE_W-1:0] ZB = '0;

    typedef struct packed {
        sxs_state_e        st;
        sxs_op_e           op;
        logic              use_u;
        logic [MASK_W-1:0] rem;
        logic              hi_done;
        logic [BYTE_W-1:0] hold;
        logic [WORD_W-1:0] sp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              is_push;
    logic [IDX_W-1:0]  cur_slot;
    logic              slot_found;
    logic              word_slot;
    logic              last_byte;
    logic [WORD_W-1:0] src_word;
    logic [MASK_W-1:0] rem_next;

    assign is_push   = (ctl_q.op == OP_PUSH) || (ctl_q.op == OP_SWI);
    assign word_slot = (cur_slot >= SLOT_WORD);
    assign last_byte = !word_slot || ctl_q.hi_done;

    sxs_pick u_pick (
        .mask   (ctl_q.rem),
        .ascend (!is_push),
        .idx    (cur_slot),
        .found  (slot_found)
    );

    sxs_srcmux #(.BYTE_W(BYTE_W)) u_src (
        .slot  (cur_slot),
        .use_u (ctl_q.use_u),
        .rd_pc (rd_pc),
        .rd_s  (rd_s),
        .rd_u  (rd_u),
        .rd_y  (rd_y),
        .rd_x  (rd_x),
        .rd_dp (rd_dp),
        .rd_b  (rd_b),
        .rd_a  (rd_a),
        .rd_cc (rd_cc),
        .value (src_word)
    );

    always_comb begin
        ctl_d     = ctl_q;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ctl_q.sp;
        mem_wdata = '0;
        wr_en     = 1'b0;
        wr_slot   = cur_slot;
        wr_data   = '0;
        done      = 1'b0;
        rem_next  = ctl_q.rem & ~(MASK_W'(1) << cur_slot);

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.op      = sxs_op_e'(cmd_op);
                    ctl_d.hi_done = 1'b0;
                    unique case (sxs_op_e'(cmd_op))
                        OP_SWI: begin
                            ctl_d.use_u = 1'b0;
                            ctl_d.rem   = '1;
                        end
                        OP_RTI: begin
                            ctl_d.use_u = 1'b0;
                            ctl_d.rem   = MASK_W'(1) << SLOT_CC;
                        end
                        default: begin
                            ctl_d.use_u = cmd_use_u;
                            ctl_d.rem   = cmd_mask;
                        end
                    endcase
                    ctl_d.sp = ctl_d.use_u ? rd_u : rd_s;
                    ctl_d.st = (ctl_d.rem == '0) ? ST_FIN : ST_XFER;
                end
            end

            ST_XFER: begin
                mem_en = 1'b1;
                if (is_push) begin
                    mem_we    = 1'b1;
                    mem_addr  = ctl_q.sp - WORD_W'(1);
                    ctl_d.sp  = ctl_q.sp - WORD_W'(1);
                    mem_wdata = (word_slot && ctl_q.hi_done)
                              ? src_word[WORD_W-1:BYTE_W]
                              : src_word[BYTE_W-1:0];
                end else begin
                    mem_addr = ctl_q.sp;
                    ctl_d.sp = ctl_q.sp + WORD_W'(1);
                    if (!last_byte) begin
                        ctl_d.hold = mem_rdata;
                    end else begin
                        wr_en   = 1'b1;
                        wr_data = word_slot ? {ctl_q.hold, mem_rdata}
                                            : {ZB, mem_rdata};
                    end
                end

                if (last_byte) begin
                    ctl_d.hi_done = 1'b0;
                    if (ctl_q.op == OP_RTI && cur_slot == SLOT_CC) begin
                        rem_next = rem_next | (mem_rdata[E_BIT]
                                 ? ~(MASK_W'(1) << SLOT_CC)
                                 : (MASK_W'(1) << SLOT_PC));
                    end
                    ctl_d.rem = rem_next;
                    if (rem_next == '0) begin
                        ctl_d.st = (ctl_q.op == OP_SWI) ? ST_VEC_HI : ST_FIN;
                    end
                end else begin
                    ctl_d.hi_done = 1'b1;
                end
            end

            ST_VEC_HI: begin
                mem_en     = 1'b1;
                mem_addr   = VEC_ADDR;
                ctl_d.hold = mem_rdata;
                wr_en      = 1'b1;
                wr_slot    = SLOT_CC;
                wr_data    = {ZB, rd_cc | SWI_CC_SET};
                ctl_d.st   = ST_VEC_LO;
            end

            ST_VEC_LO: begin
                mem_en   = 1'b1;
                mem_addr = VEC_ADDR + WORD_W'(1);
                wr_en    = 1'b1;
                wr_slot  = SLOT_PC;
                wr_data  = {ctl_q.hold, mem_rdata};
                ctl_d.st = ST_FIN;
            end

            ST_FIN: begin
                done     = 1'b1;
                ctl_d.st = ST_IDLE;
            end

            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.st != ST_IDLE);
    assign done_sp    = ctl_q.sp;
    assign done_use_u = ctl_q.use_u;

    // Idle cycles are silent on every output strobe.
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) |-> (!mem_en && !wr_en && !done));

    // Every transfer cycle moves the working pointer by exactly one.
    assert_sp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_XFER) |=> ((ctl_q.sp == $past(ctl_q.sp) + WORD_W'(1)) ||
                                   (ctl_q.sp == $past(ctl_q.sp) - WORD_W'(1))));

    // A transfer cycle always has a slot to work on.
    assert_pick_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_XFER) |-> slot_found);

    // An empty push or pull mask finishes next cycle with no memory traffic.
    assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !cmd_op[1] && cmd_mask == '0) |=> (done && !mem_en));

    // done never lasts longer than one cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A command in flight cannot be replaced by a new one.
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ctl_q.op) && $stable(ctl_q.use_u)));
endmodule

// File: tb/tb_stack_xfer_seq.sv
`timescale 1ns/1ps
module tb_stack_xfer_seq;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        cmd_valid, cmd_use_u;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_mask;
    logic        busy, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] r_pc, r_s, r_u, r_y, r_x;
    logic [7:0]  r_dp, r_b, r_a, r_cc;
    logic        wr_en, done, done_use_u;
    logic [2:0]  wr_slot;
    logic [15:0] wr_data, done_sp;

    logic [7:0] mem_m [0:255];
    assign mem_rdata = mem_m[mem_addr[7:0]];
    always @(posedge clk) if (mem_en && mem_we) mem_m[mem_addr[7:0]] <= mem_wdata;

    stack_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .cmd_use_u(cmd_use_u), .busy(busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rd_pc(r_pc), .rd_s(r_s), .rd_u(r_u), .rd_y(r_y), .rd_x(r_x),
        .rd_dp(r_dp), .rd_b(r_b), .rd_a(r_a), .rd_cc(r_cc),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
        .done(done), .done_use_u(done_use_u), .done_sp(done_sp)
    );

    typedef struct {
        logic        bz, en, we;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic        rwe;
        logic [2:0]  rid;
        logic [15:0] rwd;
        logic        dn, du;
        logic [15:0] dsp;
        string       tag;
    } ev_t;

    ev_t exq[$];
    int  vec = 0;
    int  bad = 0;

    function automatic ev_t quiet(string tag);
        ev_t e;
        e = '{bz:0, en:0, we:0, addr:0, wd:0, rwe:0, rid:0, rwd:0, dn:0, du:0, dsp:0, tag:tag};
        return e;
    endfunction

    function automatic void add_mem(logic we, logic [15:0] a, logic [7:0] wd,
                                    logic rwe, logic [2:0] rid, logic [15:0] rwd, string tag);
        ev_t e;
        e = quiet(tag);
        e.bz = 1; e.en = 1; e.we = we; e.addr = a; e.wd = wd;
        e.rwe = rwe; e.rid = rid; e.rwd = rwd;
        exq.push_back(e);
    endfunction

    function automatic void add_fin(logic [15:0] sp, logic uu, string tag);
        ev_t e;
        e = quiet(tag);
        e.bz = 1; e.dn = 1; e.dsp = sp; e.du = uu;
        exq.push_back(e);
    endfunction

    function automatic logic [15:0] regval(int slot, logic uu);
        case (slot)
            7: return r_pc;
            6: return uu ? r_s : r_u;
            5: return r_y;
            4: return r_x;
            3: return {8'h00, r_dp};
            2: return {8'h00, r_b};
            1: return {8'h00, r_a};
            default: return {8'h00, r_cc};
        endcase
    endfunction

    function automatic void model_push(logic [7:0] m, logic uu, string tag, inout logic [15:0] sp);
        logic [15:0] v;
        for (int b = 7; b >= 0; b--) begin
            if (m[b]) begin
                v = regval(b, uu);
                sp = sp - 16'd1;
                add_mem(1, sp, v[7:0], 0, 0, 0, tag);
                if (b >= 4) begin
                    sp = sp - 16'd1;
                    add_mem(1, sp, v[15:8], 0, 0, 0, tag);
                end
            end
        end
    endfunction

    function automatic void model_pull(logic [7:0] m, string tag, inout logic [15:0] sp);
        logic [7:0] hi;
        for (int b = 0; b < 8; b++) begin
            if (m[b]) begin
                if (b >= 4) begin
                    hi = mem_m[sp[7:0]];
                    add_mem(0, sp, 0, 0, 0, 0, tag);
                    sp = sp + 16'd1;
                    add_mem(0, sp, 0, 1, 3'(b), {hi, mem_m[sp[7:0]]}, tag);
                end else begin
                    add_mem(0, sp, 0, 1, 3'(b), {8'h00, mem_m[sp[7:0]]}, tag);
                end
                sp = sp + 16'd1;
            end
        end
    endfunction

    task automatic cmp(ev_t e);
        logic ok;
        vec++;
        ok = (busy === e.bz) && (mem_en === e.en) && (mem_we === e.we) &&
             (wr_en === e.rwe) && (done === e.dn);
        if (e.en && mem_addr !== e.addr) ok = 0;
        if (e.we && mem_wdata !== e.wd) ok = 0;
        if (e.rwe && (wr_slot !== e.rid || wr_data !== e.rwd)) ok = 0;
        if (e.dn && (done_sp !== e.dsp || done_use_u !== e.du)) ok = 0;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got bz=%b en=%b we=%b a=%h wd=%h rwe=%b id=%0d rd=%h dn=%b du=%b sp=%h | exp bz=%b en=%b we=%b a=%h wd=%h rwe=%b id=%0d rd=%h dn=%b du=%b sp=%h",
                     e.tag, busy, mem_en, mem_we, mem_addr, mem_wdata, wr_en, wr_slot, wr_data,
                     done, done_use_u, done_sp, e.bz, e.en, e.we, e.addr, e.wd, e.rwe, e.rid,
                     e.rwd, e.dn, e.du, e.dsp);
        end
    endtask

    // Builds the expected cycle list, issues the command and compares each cycle.
    task automatic run(input logic [1:0] op, input logic [7:0] mask, input logic uu,
                       input bit noise, input string tag);
        logic [15:0] sp;
        logic [7:0]  m;
        int n;
        exq.delete();
        case (op)
            2'd0: begin
                sp = uu ? r_u : r_s;
                model_push(mask, uu, tag, sp);
                add_fin(sp, uu, (mask == 0) ? "R8" : "R5,R9");
            end
            2'd1: begin
                sp = uu ? r_u : r_s;
                model_pull(mask, tag, sp);
                add_fin(sp, uu, (mask == 0) ? "R8" : "R5,R9");
            end
            2'd2: begin
                sp = r_s;
                model_push(8'hFF, 0, "R6", sp);
                add_mem(0, 16'hFFFA, 0, 1, 3'd0, {8'h00, r_cc | 8'hD0}, "R6");
                add_mem(0, 16'hFFFB, 0, 1, 3'd7, {mem_m[8'hFA], mem_m[8'hFB]}, "R6");
                add_fin(sp, 0, "R6");
            end
            default: begin
                sp = r_s;
                m = mem_m[sp[7:0]][7] ? 8'hFF : 8'h81;
                model_pull(m, "R7", sp);
                add_fin(sp, 0, "R7");
            end
        endcase
        @(negedge clk);
        cmp(quiet("R11"));
        cmd_valid = 1; cmd_op = op; cmd_mask = mask; cmd_use_u = uu;
        @(negedge clk);
        cmd_valid = noise;
        if (noise) begin cmd_op = 2'd1; cmd_mask = 8'h3C; cmd_use_u = ~uu; end
        n = 0;
        while (exq.size() > 0) begin
            if (n == 1) cmd_valid = 0;
            cmp(exq.pop_front());
            n++;
            @(negedge clk);
        end
        cmd_valid = 0;
        cmp(quiet(noise ? "R10" : "R9"));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got no finish, exp finish within limit");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'(i * 7 + 3);
        mem_m[8'hFA] = 8'h12;
        mem_m[8'hFB] = 8'h34;
        r_pc = 16'hA1B2; r_s = 16'h0080; r_u = 16'h00C0; r_y = 16'hC3D4; r_x = 16'hE5F6;
        r_dp = 8'h17; r_b = 8'h28; r_a = 8'h39; r_cc = 8'h4A;
        cmd_valid = 0; cmd_op = 0; cmd_mask = 0; cmd_use_u = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        cmp(quiet("R11"));
        rst_n = 1;
        @(negedge clk);
        cmp(quiet("R11"));

        run(2'd0, 8'hFF, 0, 0, "R1,R3");   // full push on S
        r_s = 16'h0074;
        run(2'd1, 8'hFF, 0, 0, "R2,R3");   // full pull on S restores values
        run(2'd0, 8'h55, 1, 0, "R4");      // push on U, slot 6 carries S
        r_u = 16'h00BA;
        run(2'd1, 8'hAA, 1, 0, "R4");      // pull on U
        run(2'd0, 8'h00, 0, 0, "R8");      // empty push
        run(2'd1, 8'h00, 1, 0, "R8");      // empty pull
        r_s = 16'h0001;
        run(2'd0, 8'h07, 0, 0, "R1");      // pointer wraps through 0000
        r_s = 16'h0060; r_cc = 8'hC5;
        run(2'd2, 8'h00, 1, 1, "R6");      // interrupt entry, command held while busy (R10)
        r_s = 16'h0054;
        run(2'd3, 8'h00, 1, 0, "R7");      // return with restore-all flag set
        r_s = 16'h0040; r_cc = 8'h05;
        run(2'd0, 8'h81, 0, 0, "R1");
        r_s = 16'h003D;
        run(2'd3, 8'h00, 0, 0, "R7");      // return with flag clear: CC then PC only

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule